// File: doc/BRIEF.md
# Frame Size Statistics Counters

This block holds the statistics counters of an Ethernet MAC for both the transmit path and the receive path. Each path reports a completed frame with a one-cycle done pulse and the frame length in bytes. On that edge the block updates the counters for that direction:

- the frame counter and the good-frame counter;
- the byte counter and the good-byte counter;
- exactly one length-class counter, chosen by the frame length.

All counters are 32 bits wide and sit in a word array. The host reads and writes that array through a simple byte-addressed port. Some words of the array are never touched by the frame logic, such as the error, collision and drop words. They behave as plain host-writable storage.

The host sees word `k` at byte offset `0x200 + 4*k`. The two least significant address bits are ignored. A read outside that window returns zero, and a write outside it has no effect. Reads are combinational from the stored words. Writes and counter updates take effect on the rising clock edge.

Top module: `frame_stats_bank`

## Requirements
- R1: A high `tx_done` adds one to word 1 (transmit frames) on that clock edge.
- R2: A high `rx_done` adds one to word 33 (receive frames) on that clock edge.
- R3: A frame adds its length to the byte word of its direction: word 17 for transmit, word 49 for receive.
- R4: A frame also adds one to the good-frame word (19 transmit, 51 receive) and adds its length to the good-byte word (29 transmit, 56 receive).
- R5: A frame adds one to exactly one class word. The transmit class words are listed below; each receive class word is the transmit word plus 32.
  - Word 7: length below 64.
  - Word 10: length exactly 64.
  - Word 11: length 65 to 127.
  - Word 12: length 128 to 255.
  - Word 13: length 256 to 511.
  - Word 14: length 512 to 1023.
  - Word 15: length 1024 to 2047.
  - Word 16: length 2048 or more.
- R6: `host_rdata` shows word `(host_addr-0x200)>>2` while `host_addr` lies in 0x200 to 0x2FF, and reads zero elsewhere.
- R7: A `host_wr` inside the window loads `host_wdata` into the addressed word. A `host_wr` outside the window changes no word.
- R8: When a host write and a frame update target the same word on the same edge, the word takes the written value.
- R9: Counters wrap modulo 2^32 and never saturate.
- R10: A transmit frame and a receive frame on the same edge are both counted in full.
- R11: After reset every word reads zero. A word that no frame update drives changes only through host writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_done | input | 1 | Transmit frame completed this cycle |
| tx_len | input | 16 | Byte length of the transmit frame |
| rx_done | input | 1 | Receive frame completed this cycle |
| rx_len | input | 16 | Byte length of the receive frame |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 10 | Host byte address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data of the addressed word |

## Verification
Some properties are checked on every cycle:
- the transmit and receive frame words step by exactly one;
- the transmit byte word grows by the sampled length;
- a host write lands on the addressed word;
- the array stays frozen on cycles with no frame and no write;
- every frame picks exactly one length class.

The bench shows the behaviours that depend on chosen data:
- the boundaries of every length class;
- wrap-around at 2^32;
- a host write that collides with a frame update of the same word;
- writes outside the window;
- zero reads outside the window;
- simultaneous transmit and receive frames.

// File: rtl/frame_stats_pkg.sv
package frame_stats_pkg;

   localparam int NUM_CLASSES = 8;

   // Word map of one direction. Receive words sit at RX_BASE above the
   // transmit words, except the good-byte word which has its own slot.
   localparam int RX_BASE     = 32;
   localparam int TX_PKT      = 1;
   localparam int TX_OCT      = 17;
   localparam int TX_OK       = 19;
   localparam int TX_OK_OCT   = 29;
   localparam int RX_PKT      = RX_BASE + TX_PKT;
   localparam int RX_OCT      = RX_BASE + TX_OCT;
   localparam int RX_OK       = RX_BASE + TX_OK;
   localparam int RX_OK_OCT   = 56;
   localparam int TX_FRAG     = 7;
   localparam int TX_CLS1     = 10;
   localparam int HIGHEST_IDX = RX_OK_OCT;

   typedef enum logic [2:0] {
      CLS_FRAG  = 3'd0,
      CLS_64    = 3'd1,
      CLS_127   = 3'd2,
      CLS_255   = 3'd3,
      CLS_511   = 3'd4,
      CLS_1023  = 3'd5,
      CLS_2047  = 3'd6,
      CLS_LARGE = 3'd7
   } len_class_e;

   // Smallest length that falls into class k.
   function automatic int class_floor(int k);
      case (k)
         0:       return 0;
         1:       return 64;
         2:       return 65;
         3:       return 128;
         4:       return 256;
         5:       return 512;
         6:       return 1024;
         default: return 2048;
      endcase
   endfunction

   function automatic int dir_base(bit is_rx);
      return is_rx ? RX_BASE : 0;
   endfunction

   // Word steps by one per frame.
   function automatic bit counts_frames(bit is_rx, int w);
      if (is_rx) return (w == RX_PKT) || (w == RX_OK);
      return (w == TX_PKT) || (w == TX_OK);
   endfunction

   // Word accumulates the frame length.
   function automatic bit counts_bytes(bit is_rx, int w);
      if (is_rx) return (w == RX_OCT) || (w == RX_OK_OCT);
      return (w == TX_OCT) || (w == TX_OK_OCT);
   endfunction

   // Length class held by word w, or -1.
   function automatic int class_of_word(bit is_rx, int w);
      int rel;
      rel = w - dir_base(is_rx);
      if (rel == TX_FRAG) return 0;
      if (rel >= TX_CLS1 && rel < TX_CLS1 + NUM_CLASSES - 1) return rel - TX_CLS1 + 1;
      return -1;
   endfunction

endpackage

// File: rtl/frame_len_classifier.sv
module frame_len_classifier
   import frame_stats_pkg::*;
#(
   parameter int LEN_W = 16
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   done,
   input  logic [LEN_W-1:0]       len,
   output logic [NUM_CLASSES-1:0] cls_oh
);

   if (LEN_W < 12) begin : g_bad_len
      $error("LEN_W must hold lengths of 2048 and more");
   end

   for (genvar k = 0; k < NUM_CLASSES; k++) begin : g_cls
      localparam logic [LEN_W-1:0] LO = LEN_W'(class_floor(k));
      if (k == NUM_CLASSES - 1) begin : g_top
         assign cls_oh[k] = (len >= LO);
      end else begin : g_mid
         localparam logic [LEN_W-1:0] NEXT = LEN_W'(class_floor(k + 1));
         assign cls_oh[k] = (len >= LO) && (len < NEXT);
      end
   end

   assert_class_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $countones(cls_oh) == 1);

endmodule

// File: rtl/frame_stats_dir_adder.sv
module frame_stats_dir_adder
   import frame_stats_pkg::*;
#(
   parameter int LEN_W     = 16,
   parameter int CNT_W     = 32,
   parameter int NUM_WORDS = 64,
   parameter bit IS_RX     = 1'b0
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                done,
   input  logic [LEN_W-1:0]                    len,
   output logic [NUM_WORDS-1:0][CNT_W-1:0]     add_vec
);

   if (CNT_W < LEN_W) begin : g_bad_cnt
      $error("CNT_W must be at least LEN_W");
   end

   logic [NUM_CLASSES-1:0] cls_oh;

   frame_len_classifier #(.LEN_W(LEN_W)) i_classifier (
      .clk    (clk),
      .rst_n  (rst_n),
      .done   (done),
      .len    (len),
      .cls_oh (cls_oh)
   );

   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      localparam int CI = class_of_word(IS_RX, w);
      if (counts_frames(IS_RX, w)) begin : g_frames
         assign add_vec[w] = CNT_W'(done);
      end else if (counts_bytes(IS_RX, w)) begin : g_bytes
         assign add_vec[w] = done ? CNT_W'(len) : '0;
      end else if (CI >= 0) begin : g_class
         assign add_vec[w] = CNT_W'(done & cls_oh[CI]);
      end else begin : g_idle
         assign add_vec[w] = '0;
      end
   end

endmodule

// File: rtl/frame_stats_word_bank.sv
module frame_stats_word_bank #(
   parameter int CNT_W     = 32,
   parameter int NUM_WORDS = 64,
   localparam int IDX_W    = $clog2(NUM_WORDS)
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [NUM_WORDS-1:0][CNT_W-1:0] inc_tx,
   input  logic [NUM_WORDS-1:0][CNT_W-1:0] inc_rx,
   input  logic                            wr_en,
   input  logic [IDX_W-1:0]                wr_idx,
   input  logic [CNT_W-1:0]                wr_data,
   output logic [NUM_WORDS-1:0][CNT_W-1:0] words
);

   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      logic hit;
      assign hit = wr_en && (wr_idx == IDX_W'(w));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            words[w] <= '0;
         end else if (hit) begin
            words[w] <= wr_data;
         end else begin
            words[w] <= words[w] + inc_tx[w] + inc_rx[w];
         end
      end
   end

endmodule

// File: rtl/frame_stats_bank.sv
module frame_stats_bank
   import frame_stats_pkg::*;
#(
   parameter int LEN_W     = 16,
   parameter int CNT_W     = 32,
   parameter int NUM_WORDS = 64,
   parameter int ADDR_W    = 10,
   parameter int BASE_ADDR = 'h200
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_done,
   input  logic [LEN_W-1:0]  tx_len,
   input  logic              rx_done,
   input  logic [LEN_W-1:0]  rx_len,
   input  logic              host_wr,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [CNT_W-1:0]  host_wdata,
   output logic [CNT_W-1:0]  host_rdata
);

   localparam int IDX_W = $clog2(NUM_WORDS);
   localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE_ADDR);
   localparam logic [ADDR_W:0] WIN_BYTES = (ADDR_W + 1)'(4 * NUM_WORDS);

   if (NUM_WORDS != (1 << IDX_W) || NUM_WORDS <= HIGHEST_IDX) begin : g_bad_words
      $error("NUM_WORDS must be a power of two above the highest counter index");
   end
   if ((BASE_ADDR % 4) != 0 || BASE_ADDR + 4 * NUM_WORDS > (1 << ADDR_W)) begin : g_bad_addr
      $error("counter window must be word aligned and fit the address space");
   end

   // Address decode
   logic [ADDR_W-1:0] offset;
   logic              in_win;
   logic [IDX_W-1:0]  idx;
   logic              wr_hit;
   logic [1:0]        unused_lsbs;

   assign offset      = host_addr - BASE_A;
   assign in_win      = (host_addr >= BASE_A) && ({1'b0, offset} < WIN_BYTES);
   assign idx         = offset[IDX_W+1:2];
   assign unused_lsbs = offset[1:0];
   assign wr_hit      = host_wr && in_win;

   // Per-direction update vectors
   logic [1:0]                                 dir_done;
   logic [1:0][LEN_W-1:0]                      dir_len;
   logic [1:0][NUM_WORDS-1:0][CNT_W-1:0]       dir_add;
   logic [NUM_WORDS-1:0][CNT_W-1:0]            words;

   assign dir_done = {rx_done, tx_done};
   assign dir_len  = {rx_len, tx_len};

   for (genvar d = 0; d < 2; d++) begin : g_dir
      frame_stats_dir_adder #(
         .LEN_W     (LEN_W),
         .CNT_W     (CNT_W),
         .NUM_WORDS (NUM_WORDS),
         .IS_RX     (d == 1)
      ) i_adder (
         .clk     (clk),
         .rst_n   (rst_n),
         .done    (dir_done[d]),
         .len     (dir_len[d]),
         .add_vec (dir_add[d])
      );
   end

   frame_stats_word_bank #(
      .CNT_W     (CNT_W),
      .NUM_WORDS (NUM_WORDS)
   ) i_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc_tx  (dir_add[0]),
      .inc_rx  (dir_add[1]),
      .wr_en   (wr_hit),
      .wr_idx  (idx),
      .wr_data (host_wdata),
      .words   (words)
   );

   assign host_rdata = in_win ? words[idx] : '0;

   // Properties
   assert_tx_pkt_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_done && !(wr_hit && idx == IDX_W'(TX_PKT)))
      |=> words[TX_PKT] == $past(words[TX_PKT]) + CNT_W'(1));

   assert_rx_pkt_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_done && !(wr_hit && idx == IDX_W'(RX_PKT)))
      |=> words[RX_PKT] == $past(words[RX_PKT]) + CNT_W'(1));

   assert_tx_oct_add_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_done && !(wr_hit && idx == IDX_W'(TX_OCT)))
      |=> words[TX_OCT] == $past(words[TX_OCT]) + CNT_W'($past(tx_len)));

   assert_host_write_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit |=> words[$past(idx)] == $past(host_wdata));

   assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_done && !rx_done && !wr_hit) |=> $stable(words));

endmodule

// File: tb/test_frame_stats_bank.sv
module test_frame_stats_bank;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tx_done = 1'b0;
   logic [15:0] tx_len = '0;
   logic        rx_done = 1'b0;
   logic [15:0] rx_len = '0;
   logic        host_wr = 1'b0;
   logic [9:0]  host_addr = 10'h000;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;

   int n_checks = 0;
   int n_errors = 0;
   bit live_check = 1'b0;
   logic [31:0] model [64];

   always #4 clk = ~clk;

   frame_stats_bank i_frame_stats_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .tx_done    (tx_done),
      .tx_len     (tx_len),
      .rx_done    (rx_done),
      .rx_len     (rx_len),
      .host_wr    (host_wr),
      .host_addr  (host_addr),
      .host_wdata (host_wdata),
      .host_rdata (host_rdata)
   );

   function automatic int class_word(bit rx, int len);
      int w;
      if (len < 64) w = 7;
      else if (len == 64) w = 10;
      else if (len < 128) w = 11;
      else if (len < 256) w = 12;
      else if (len < 512) w = 13;
      else if (len < 1024) w = 14;
      else if (len < 2048) w = 15;
      else w = 16;
      return rx ? w + 32 : w;
   endfunction

   function automatic logic [31:0] expect_rd(logic [9:0] a);
      if (a >= 10'h200 && a <= 10'h2FF) return model[(int'(a) - 'h200) >> 2];
      return 32'h0;
   endfunction

   // Behavioural reference model
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < 64; i++) model[i] = '0;
      end else begin
         if (tx_done) begin
            model[1]  = model[1] + 1;
            model[17] = model[17] + 32'(tx_len);
            model[19] = model[19] + 1;
            model[29] = model[29] + 32'(tx_len);
            model[class_word(1'b0, int'(tx_len))] = model[class_word(1'b0, int'(tx_len))] + 1;
         end
         if (rx_done) begin
            model[33] = model[33] + 1;
            model[49] = model[49] + 32'(rx_len);
            model[51] = model[51] + 1;
            model[56] = model[56] + 32'(rx_len);
            model[class_word(1'b1, int'(rx_len))] = model[class_word(1'b1, int'(rx_len))] + 1;
         end
         if (host_wr && host_addr >= 10'h200 && host_addr <= 10'h2FF)
            model[(int'(host_addr) - 'h200) >> 2] = host_wdata;
      end
   end

   task automatic check(string req, logic [31:0] got, logic [31:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_errors++;
         $display("FAIL %s: addr %h got %h expected %h", req, host_addr, got, exp);
      end
   endtask

   // Compare on every clock, away from the edge
   always @(posedge clk) begin
      #2;
      if (live_check && rst_n) check("R6", host_rdata, expect_rd(host_addr));
   end

   task automatic cycle(bit td, int tl, bit rd, int rl, bit wr, int a, logic [31:0] d);
      @(negedge clk);
      tx_done = td; tx_len = 16'(tl);
      rx_done = rd; rx_len = 16'(rl);
      host_wr = wr; host_addr = 10'(a); host_wdata = d;
      @(negedge clk);
      tx_done = 1'b0; rx_done = 1'b0; host_wr = 1'b0;
   endtask

   task automatic sweep(string req);
      for (int i = 0; i < 64; i++) begin
         @(negedge clk);
         host_addr = 10'('h200 + 4 * i);
         #1;
         check(req, host_rdata, model[i]);
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   endtask

   initial begin
      #(8 * 200000);
      n_errors++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      int sizes [16] = '{0, 10, 63, 64, 65, 127, 128, 255, 256, 511, 512,
                         1023, 1024, 2047, 2048, 65535};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      live_check = 1'b1;
      sweep("R11 reset");

      // Transmit length classes, boundaries on both sides
      foreach (sizes[i]) cycle(1'b1, sizes[i], 1'b0, 0, 1'b0, 0, '0);
      sweep("R1 R3 R4 R5 tx");

      // Receive length classes, back to back
      foreach (sizes[i]) begin
         @(negedge clk);
         rx_done = 1'b1; rx_len = 16'(sizes[i]);
      end
      @(negedge clk) rx_done = 1'b0;
      sweep("R2 R3 R4 R5 rx");

      // Simultaneous transmit and receive
      cycle(1'b1, 64, 1'b1, 64, 1'b0, 0, '0);
      cycle(1'b1, 1500, 1'b1, 40, 1'b0, 0, '0);
      cycle(1'b1, 3000, 1'b1, 200, 1'b0, 0, '0);
      sweep("R10");

      // Host writes inside the window
      cycle(1'b0, 0, 1'b0, 0, 1'b1, 'h200, 32'hA5A5_0001);
      cycle(1'b0, 0, 1'b0, 0, 1'b1, 'h290, 32'h0BAD_F00D);
      sweep("R7 in-window");

      // Host write collides with frame updates of the same words
      cycle(1'b1, 100, 1'b0, 0, 1'b1, 'h204, 32'h0000_1234);
      cycle(1'b1, 100, 1'b0, 0, 1'b1, 'h22C, 32'h0000_0777);
      cycle(1'b0, 0, 1'b1, 70, 1'b1, 'h2C4, 32'h0000_0055);
      sweep("R8");

      // Wrap-around
      cycle(1'b0, 0, 1'b0, 0, 1'b1, 'h204, 32'hFFFF_FFFF);
      cycle(1'b0, 0, 1'b0, 0, 1'b1, 'h244, 32'hFFFF_FFF0);
      cycle(1'b1, 100, 1'b0, 0, 1'b0, 0, '0);
      @(negedge clk) host_addr = 10'h204;
      #1 check("R9 pkt wrap", host_rdata, 32'h0000_0000);
      @(negedge clk) host_addr = 10'h244;
      #1 check("R9 octet wrap", host_rdata, 32'h0000_0054);

      // Writes outside the window, reads outside and unaligned
      cycle(1'b0, 0, 1'b0, 0, 1'b1, 'h100, 32'hDEAD_BEEF);
      cycle(1'b0, 0, 1'b0, 0, 1'b1, 'h300, 32'hDEAD_BEEF);
      cycle(1'b0, 0, 1'b0, 0, 1'b1, 'h1FC, 32'hDEAD_BEEF);
      @(negedge clk) host_addr = 10'h100;
      #1 check("R6 outside read", host_rdata, 32'h0);
      @(negedge clk) host_addr = 10'h3FC;
      #1 check("R6 outside read", host_rdata, 32'h0);
      @(negedge clk) host_addr = 10'h207;
      #1 check("R6 low bits", host_rdata, model[1]);
      sweep("R7 outside");

      // Undriven words after all traffic
      @(negedge clk) host_addr = 10'h210;
      #1 check("R11 undriven", host_rdata, 32'h0);
      @(negedge clk) host_addr = 10'h290;
      #1 check("R11 undriven", host_rdata, 32'h0BAD_F00D);
      sweep("R11 final");

      live_check = 1'b0;
      finish_run();
   end

endmodule